// File: doc/BRIEF.md
# Fixed-Point Add/Subtract and Extend Unit

This unit performs the integer arithmetic of a 64-bit fixed-point pipe. It covers plain add, subtract-from, add with carry-in, add carry-in minus one, add carry-in to zero, add of a shifted 16-bit immediate, and sign extension of a byte, halfword or word. With every operation it takes the incoming exception-status bits: summary overflow, overflow, 32-bit overflow, carry and 32-bit carry. It returns the result, the updated status bits and, when recording is requested, a 4-bit condition field.

Operations enter on a valid/ready stream and leave on a second valid/ready stream one register stage later. A transfer takes place on a rising clock edge where valid and ready are both high. The upstream side may not change its payload while valid is high and ready is low. The unit raises `in_ready` whenever its output register is empty or is being drained in the same cycle, so a consumer that holds `out_ready` high gets one result per clock. When `out_ready` is low, the output payload is held. Decoding, register-file access and writeback ordering belong to the surrounding pipe.

Top module: `fxu_addsub`

## Requirements
- R1: `in_op` codes are 0 add, 1 subtract-from, 2 add-with-carry, 3 add-carry-minus-one, 4 add-carry-to-zero, 5 add-shifted-immediate, 6 extend-byte, 7 extend-half, 8 extend-word. Codes 9 to 15 give a zero result and leave all status bits unchanged. Add (code 0) returns A + B modulo 2^64.
- R2: Subtract-from returns the complement of A plus B plus 1, modulo 2^64, which equals B − A.
- R3: Codes 2, 3 and 4 return A + B + CA, A + CA + 2^64 − 1 and A + CA respectively, with the incoming `in_ca` as carry-in. They replace carry with the carry out of bit 63, and carry32 with the carry out of the low 32-bit sum (carry-in included).
- R4: All codes other than 2, 3 and 4 pass `in_ca` and `in_ca32` through unchanged.
- R5: Code 5 sign-extends the 16-bit immediate, shifts it left by 16 and adds it to A. When `in_src_zero` is high, the literal 0 replaces A.
- R6: Codes 6, 7 and 8 copy bit 7, 15 or 31 of A into all higher bits and keep the bits at and below it.
- R7: For codes 0 to 4 with `in_oe` high, overflow is set on signed 64-bit overflow and overflow32 on signed overflow of the low 32 bits. Summary overflow becomes the incoming summary overflow ORed with the new overflow.
- R8: With `in_oe` low, or for any code other than 0 to 4, overflow, overflow32 and summary overflow pass through unchanged.
- R9: With `in_rec` high, `out_cr0_valid` is 1 and `out_cr0` holds {negative, positive non-zero, zero, summary overflow after this operation}, from bit 3 down to bit 0, with exactly one of bits 3..1 set. With `in_rec` low, `out_cr0_valid` and `out_cr0` are 0.
- R10: An operation accepted on one edge is presented on `out_valid` at that edge and kept until drained. `in_ready` equals (not `out_valid`) or `out_ready`.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and every output payload bit stay unchanged.
- R12: While `rst_n` is low and after its release, `out_valid` is 0 and `in_ready` is 1 until the first transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_op | input | 4 | Operation code (see R1) |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| in_imm | input | 16 | Immediate for code 5 |
| in_src_zero | input | 1 | Code 5 uses 0 instead of A |
| in_rec | input | 1 | Produce the condition field |
| in_oe | input | 1 | Update the overflow bits |
| in_so | input | 1 | Incoming summary overflow |
| in_ov | input | 1 | Incoming overflow |
| in_ov32 | input | 1 | Incoming 32-bit overflow |
| in_ca | input | 1 | Incoming carry |
| in_ca32 | input | 1 | Incoming 32-bit carry |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 64 | Result |
| out_so | output | 1 | Updated summary overflow |
| out_ov | output | 1 | Updated overflow |
| out_ov32 | output | 1 | Updated 32-bit overflow |
| out_ca | output | 1 | Updated carry |
| out_ca32 | output | 1 | Updated 32-bit carry |
| out_cr0 | output | 4 | Condition field |
| out_cr0_valid | output | 1 | Condition field is meaningful |

## Verification
The sticky-overflow check assumes the incoming status is architecturally consistent: summary overflow is never low while overflow is high. The random stimulus enforces this by ORing the generated overflow bit into summary overflow. The hold checks assume that the producer keeps its payload stable while stalled. The bench only reloads its vector after a transfer, and it mixes random back-pressure with operand values biased toward 0, all-ones and the signed extremes.

// File: rtl/fxu_pkg.sv
package fxu_pkg;
  localparam int unsigned OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD   = 4'd0,
    OP_SUBF  = 4'd1,
    OP_ADDC  = 4'd2,
    OP_ADDM1 = 4'd3,
    OP_ADDZ  = 4'd4,
    OP_ADDSH = 4'd5,
    OP_EXTB  = 4'd6,
    OP_EXTH  = 4'd7,
    OP_EXTW  = 4'd8
  } fxu_op_e;

  typedef struct packed {
    logic so;
    logic ov;
    logic ov32;
    logic ca;
    logic ca32;
  } fxu_stat_t;
endpackage

// File: rtl/fxu_opsel.sv
module fxu_opsel
  import fxu_pkg::*;
#(
  parameter int unsigned W     = 64,
  parameter int unsigned IMM_W = 16
) (
  input  fxu_op_e          op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [IMM_W-1:0] imm,
  input  logic             src_zero,
  input  logic             ca_in,
  output logic [W-1:0]     x,
  output logic [W-1:0]     y,
  output logic             cin,
  output logic             carry_wr,
  output logic             ov_cap,
  output logic             ext_sel,
  output logic [1:0]       ext_kind
);
  localparam int unsigned PAD_W = W - 2 * IMM_W;

  logic [W-1:0] imm_shifted;
  assign imm_shifted = {{PAD_W{imm[IMM_W-1]}}, imm, {IMM_W{1'b0}}};

  always_comb begin
    x        = '0;
    y        = '0;
    cin      = 1'b0;
    carry_wr = 1'b0;
    ov_cap   = 1'b0;
    ext_sel  = 1'b0;
    ext_kind = 2'd0;
    unique case (op)
      OP_ADD:   begin x = a;  y = b;  ov_cap = 1'b1; end
      OP_SUBF:  begin x = ~a; y = b;  cin = 1'b1; ov_cap = 1'b1; end
      OP_ADDC:  begin x = a;  y = b;  cin = ca_in; ov_cap = 1'b1; carry_wr = 1'b1; end
      OP_ADDM1: begin x = a;  y = '1; cin = ca_in; ov_cap = 1'b1; carry_wr = 1'b1; end
      OP_ADDZ:  begin x = a;  y = '0; cin = ca_in; ov_cap = 1'b1; carry_wr = 1'b1; end
      OP_ADDSH: begin x = src_zero ? '0 : a; y = imm_shifted; end
      OP_EXTB:  begin ext_sel = 1'b1; ext_kind = 2'd0; end
      OP_EXTH:  begin ext_sel = 1'b1; ext_kind = 2'd1; end
      OP_EXTW:  begin ext_sel = 1'b1; ext_kind = 2'd2; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/fxu_adder.sv
module fxu_adder #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         co,
  output logic         co_half,
  output logic         ovf,
  output logic         ovf_half
);
  localparam int unsigned HALF = W / 2;

  logic [W:0]    full;
  logic [HALF:0] low;

  assign full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign low  = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + {{HALF{1'b0}}, cin};

  assign sum      = full[W-1:0];
  assign co       = full[W];
  assign co_half  = low[HALF];
  assign ovf      = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
  assign ovf_half = (x[HALF-1] == y[HALF-1]) && (low[HALF-1] != x[HALF-1]);
endmodule

// File: rtl/fxu_sext.sv
module fxu_sext #(
  parameter int unsigned W = 64
) (
  input  logic [W/2-1:0] lo,
  input  logic [1:0]     kind,
  output logic [W-1:0]   ext
);
  localparam int unsigned HALF = W / 2;
  localparam int unsigned NKIND = 3;

  logic [W-1:0] cand [NKIND];

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    localparam int unsigned SRC_W = (k == 2) ? HALF : (8 << k);
    assign cand[k] = {{(W-SRC_W){lo[SRC_W-1]}}, lo[SRC_W-1:0]};
  end

  always_comb begin
    ext = cand[0];
    if (kind == 2'd1) ext = cand[1];
    else if (kind == 2'd2) ext = cand[2];
  end
endmodule

// File: rtl/fxu_flags.sv
module fxu_flags
  import fxu_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] res,
  input  fxu_stat_t    stat_in,
  input  logic         carry_wr,
  input  logic         ov_cap,
  input  logic         oe,
  input  logic         rec,
  input  logic         co,
  input  logic         co_half,
  input  logic         ovf,
  input  logic         ovf_half,
  output fxu_stat_t    stat_out,
  output logic [3:0]   cr0,
  output logic         cr0_valid
);
  logic ov_wr;
  assign ov_wr = oe && ov_cap;

  always_comb begin
    stat_out = stat_in;
    if (carry_wr) begin
      stat_out.ca   = co;
      stat_out.ca32 = co_half;
    end
    if (ov_wr) begin
      stat_out.ov   = ovf;
      stat_out.ov32 = ovf_half;
      stat_out.so   = stat_in.so | ovf;
    end
  end

  logic neg, zero;
  assign neg  = res[W-1];
  assign zero = (res == '0);

  assign cr0_valid = rec;
  assign cr0 = rec ? {neg, !neg && !zero, zero, stat_out.so} : 4'b0000;
endmodule

// File: rtl/fxu_addsub.sv
module fxu_addsub
  import fxu_pkg::*;
#(
  parameter int unsigned W     = 64,
  parameter int unsigned IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [IMM_W-1:0] in_imm,
  input  logic             in_src_zero,
  input  logic             in_rec,
  input  logic             in_oe,
  input  logic             in_so,
  input  logic             in_ov,
  input  logic             in_ov32,
  input  logic             in_ca,
  input  logic             in_ca32,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_res,
  output logic             out_so,
  output logic             out_ov,
  output logic             out_ov32,
  output logic             out_ca,
  output logic             out_ca32,
  output logic [3:0]       out_cr0,
  output logic             out_cr0_valid
);
  localparam int unsigned HALF = W / 2;

  fxu_op_e   op;
  fxu_stat_t stat_in, stat_nx, stat_q;
  logic [W-1:0] x, y, sum, ext, res_nx;
  logic cin, carry_wr, ov_cap, ext_sel;
  logic [1:0] ext_kind;
  logic co, co_half, ovf, ovf_half;
  logic [3:0] cr0_nx;
  logic cr0_valid_nx;
  logic take;

  assign op      = fxu_op_e'(in_op);
  assign stat_in = '{so: in_so, ov: in_ov, ov32: in_ov32, ca: in_ca, ca32: in_ca32};

  fxu_opsel #(.W(W), .IMM_W(IMM_W)) u_opsel (
    .op(op), .a(in_a), .b(in_b), .imm(in_imm), .src_zero(in_src_zero), .ca_in(in_ca),
    .x(x), .y(y), .cin(cin), .carry_wr(carry_wr), .ov_cap(ov_cap),
    .ext_sel(ext_sel), .ext_kind(ext_kind)
  );

  fxu_adder #(.W(W)) u_adder (
    .x(x), .y(y), .cin(cin), .sum(sum), .co(co), .co_half(co_half),
    .ovf(ovf), .ovf_half(ovf_half)
  );

  fxu_sext #(.W(W)) u_sext (
    .lo(in_a[HALF-1:0]), .kind(ext_kind), .ext(ext)
  );

  assign res_nx = ext_sel ? ext : sum;

  fxu_flags #(.W(W)) u_flags (
    .res(res_nx), .stat_in(stat_in), .carry_wr(carry_wr), .ov_cap(ov_cap),
    .oe(in_oe), .rec(in_rec), .co(co), .co_half(co_half), .ovf(ovf),
    .ovf_half(ovf_half), .stat_out(stat_nx), .cr0(cr0_nx), .cr0_valid(cr0_valid_nx)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_res       <= '0;
      stat_q        <= '0;
      out_cr0       <= '0;
      out_cr0_valid <= 1'b0;
    end else begin
      if (take) begin
        out_valid     <= 1'b1;
        out_res       <= res_nx;
        stat_q        <= stat_nx;
        out_cr0       <= cr0_nx;
        out_cr0_valid <= cr0_valid_nx;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_so   = stat_q.so;
  assign out_ov   = stat_q.ov;
  assign out_ov32 = stat_q.ov32;
  assign out_ca   = stat_q.ca;
  assign out_ca32 = stat_q.ca32;
endmodule

// File: rtl/fxu_addsub_chk.sv
module fxu_addsub_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_res,
  input logic         out_so,
  input logic         out_ov,
  input logic         out_ov32,
  input logic         out_ca,
  input logic         out_ca32,
  input logic [3:0]   out_cr0,
  input logic         out_cr0_valid
);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_cr0)
      && $stable({out_so, out_ov, out_ov32, out_ca, out_ca32, out_cr0_valid}));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_cr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cr0_valid |-> $countones(out_cr0[3:1]) == 1);

  assert_cr_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cr0_valid |-> (out_cr0[1] == (out_res == '0))
      && (out_cr0[3] == out_res[W-1]) && (out_cr0[0] == out_so));

  assert_cr_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_cr0_valid |-> out_cr0 == 4'b0000);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ov |-> out_so);
endmodule

bind fxu_addsub fxu_addsub_chk #(.W(W)) u_chk (.*);

// File: tb/test_fxu_addsub.sv
module test_fxu_addsub;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND = 400;
  localparam logic signed [67:0] MAX64 = 68'sh0_7fff_ffff_ffff_ffff;
  localparam logic signed [67:0] MIN64 = -MAX64 - 68'sd1;
  localparam logic signed [67:0] MAX32 = 68'sh7fff_ffff;
  localparam logic signed [67:0] MIN32 = -MAX32 - 68'sd1;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [3:0] in_op;
  logic [63:0] in_a, in_b, out_res;
  logic [15:0] in_imm;
  logic in_src_zero, in_rec, in_oe, in_so, in_ov, in_ov32, in_ca, in_ca32;
  logic out_so, out_ov, out_ov32, out_ca, out_ca32, out_cr0_valid;
  logic [3:0] out_cr0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fxu_addsub i_fxu_addsub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .in_src_zero(in_src_zero), .in_rec(in_rec), .in_oe(in_oe),
    .in_so(in_so), .in_ov(in_ov), .in_ov32(in_ov32), .in_ca(in_ca), .in_ca32(in_ca32),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .out_so(out_so), .out_ov(out_ov), .out_ov32(out_ov32), .out_ca(out_ca),
    .out_ca32(out_ca32), .out_cr0(out_cr0), .out_cr0_valid(out_cr0_valid)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [63:0] a, b;
    logic [15:0] imm;
    logic sz, rec, oe, so, ov, ov32, ca, ca32;
  } vec_t;

  typedef struct packed {
    logic [3:0]  op;
    logic        arith_oe;
    logic [63:0] res;
    logic so, ov, ov32, ca, ca32;
    logic [3:0]  cr;
    logic        crv;
  } exp_t;

  vec_t vecs[$];
  exp_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(vec_t v);
    exp_t e;
    logic signed [67:0] sa, sb, la, lb, s64, s32, c1;
    logic [67:0] u64, u32;
    bit arith, cwr;
    logic [63:0] r;
    sa = {{4{v.a[63]}}, v.a};
    sb = {{4{v.b[63]}}, v.b};
    la = {{36{v.a[31]}}, v.a[31:0]};
    lb = {{36{v.b[31]}}, v.b[31:0]};
    c1 = {67'd0, v.ca};
    arith = 1'b1; cwr = 1'b0; s64 = '0; s32 = '0; u64 = '0; u32 = '0; r = '0;
    case (v.op)
      4'd0: begin s64 = sa + sb; s32 = la + lb; end
      4'd1: begin s64 = sb - sa; s32 = lb - la; end
      4'd2: begin
        s64 = sa + sb + c1; s32 = la + lb + c1; cwr = 1'b1;
        u64 = {4'd0, v.a} + {4'd0, v.b} + c1;
        u32 = {36'd0, v.a[31:0]} + {36'd0, v.b[31:0]} + c1;
      end
      4'd3: begin
        s64 = sa + c1 - 68'sd1; s32 = la + c1 - 68'sd1; cwr = 1'b1;
        u64 = {4'd0, v.a} + c1 + {4'd0, {64{1'b1}}};
        u32 = {36'd0, v.a[31:0]} + c1 + {36'd0, 32'hffff_ffff};
      end
      4'd4: begin
        s64 = sa + c1; s32 = la + c1; cwr = 1'b1;
        u64 = {4'd0, v.a} + c1;
        u32 = {36'd0, v.a[31:0]} + c1;
      end
      default: arith = 1'b0;
    endcase
    if (arith) r = s64[63:0];
    case (v.op)
      4'd5: r = (v.sz ? 64'd0 : v.a) + {{32{v.imm[15]}}, v.imm, 16'h0000};
      4'd6: r = {{56{v.a[7]}}, v.a[7:0]};
      4'd7: r = {{48{v.a[15]}}, v.a[15:0]};
      4'd8: r = {{32{v.a[31]}}, v.a[31:0]};
      default: ;
    endcase
    e.op = v.op;
    e.res = r;
    e.ca   = cwr ? u64[64] : v.ca;
    e.ca32 = cwr ? u32[32] : v.ca32;
    e.arith_oe = arith && v.oe;
    if (arith && v.oe) begin
      e.ov   = (s64 > MAX64) || (s64 < MIN64);
      e.ov32 = (s32 > MAX32) || (s32 < MIN32);
      e.so   = v.so | e.ov;
    end else begin
      e.ov = v.ov; e.ov32 = v.ov32; e.so = v.so;
    end
    e.crv = v.rec;
    e.cr  = v.rec ? {r[63], !r[63] && (r != 0), r == 0, e.so} : 4'b0000;
    return e;
  endfunction

  function automatic string res_tag(logic [3:0] op);
    case (op)
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R5";
      4'd6, 4'd7, 4'd8: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic add_vec(logic [3:0] op, logic [63:0] a, logic [63:0] b, logic [15:0] imm,
                         logic sz, logic rec, logic oe, logic so, logic ov, logic ca);
    vec_t v;
    v.op = op; v.a = a; v.b = b; v.imm = imm; v.sz = sz; v.rec = rec; v.oe = oe;
    v.so = so | ov; v.ov = ov; v.ov32 = 1'b0; v.ca = ca; v.ca32 = 1'b0;
    vecs.push_back(v);
  endtask

  function automatic logic [63:0] pick64();
    case ($urandom % 6)
      0: return 64'h0;
      1: return 64'hffff_ffff_ffff_ffff;
      2: return 64'h7fff_ffff_ffff_ffff;
      3: return {$urandom, 32'h7fff_ffff};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t cur;
    exp_t e;
    bit acc, acc_prev, hold_prev;
    logic [63:0] h_res;
    logic [9:0]  h_bits;
    int idx;

    // directed corners
    add_vec(4'd0, 64'hc523e996a8ff6215, 64'he1e5b9cc9864c4a8, 16'h0, 0, 1, 0, 0, 0, 0); // R1 R9
    add_vec(4'd1, 64'h3d7f3f7ca24bac7b, 64'hf6b2ac5e13ee15c2, 16'h0, 0, 0, 0, 0, 0, 0); // R2
    add_vec(4'd1, 64'h10, 64'h5, 16'h0, 0, 1, 0, 0, 0, 0);                              // R2 negative
    add_vec(4'd8, 64'hb6a1fc6c8576af91, 64'h0, 16'h0, 0, 0, 0, 0, 0, 0);                // R6
    add_vec(4'd6, 64'h7f9497aaff900ea0, 64'h0, 16'h0, 0, 0, 0, 0, 0, 0);                // R6
    add_vec(4'd7, 64'h0000_0000_0000_7fff, 64'h0, 16'h0, 0, 1, 0, 0, 0, 0);             // R6
    add_vec(4'd3, 64'h7_ffff_ffff, 64'h0, 16'h0, 0, 1, 1, 0, 0, 0);                     // R3 ca=0
    add_vec(4'd3, 64'h7_ffff_ffff, 64'h0, 16'h0, 0, 1, 0, 1, 0, 1);                     // R3 R9 so copy
    add_vec(4'd3, 64'h7fff_ffff_ffff_ffff, 64'h0, 16'h0, 0, 1, 1, 0, 0, 1);             // R7 no ovf
    add_vec(4'd3, 64'h8000_0000_0000_0000, 64'h0, 16'h0, 0, 1, 1, 0, 0, 0);             // R7 ovf
    add_vec(4'd4, 64'h00ff00ff00ff0080, 64'h0, 16'h0, 0, 1, 1, 0, 0, 0);                // R3
    add_vec(4'd2, 64'hffff_ffff_ffff_ffff, 64'h0, 16'h0, 0, 1, 0, 0, 0, 1);             // R3 zero, carry
    add_vec(4'd5, 64'h5, 64'h0, 16'h0001, 1, 0, 0, 0, 0, 0);                            // R5 literal zero
    add_vec(4'd5, 64'h5, 64'h0, 16'h8000, 0, 1, 1, 0, 0, 0);                            // R5 R8
    add_vec(4'd0, 64'h7fff_ffff_ffff_ffff, 64'h1, 16'h0, 0, 1, 1, 0, 0, 0);             // R7
    add_vec(4'd0, 64'h7fff_ffff, 64'h1, 16'h0, 0, 0, 1, 0, 0, 0);                       // R7 ov32 only
    add_vec(4'd0, 64'h7fff_ffff_ffff_ffff, 64'h1, 16'h0, 0, 0, 0, 0, 1, 1);             // R8 R4
    add_vec(4'd11, 64'h1234, 64'h5678, 16'h0, 0, 1, 1, 1, 1, 1);                        // R1 reserved
    for (int i = 0; i < N_RAND; i++) begin
      vec_t v;
      v.op = 4'($urandom % 10);
      v.a = pick64(); v.b = pick64(); v.imm = 16'($urandom);
      v.sz = 1'($urandom); v.rec = 1'($urandom); v.oe = 1'($urandom);
      v.ov = 1'($urandom); v.ov32 = 1'($urandom); v.so = 1'($urandom) | v.ov;
      v.ca = 1'($urandom); v.ca32 = 1'($urandom);
      vecs.push_back(v);
    end

    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_op = '0; in_a = '0; in_b = '0; in_imm = '0; in_src_zero = 1'b0;
    in_rec = 1'b0; in_oe = 1'b0; in_so = 1'b0; in_ov = 1'b0; in_ov32 = 1'b0;
    in_ca = 1'b0; in_ca32 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R12", "out_valid in reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R12", "in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12", "out_valid after reset", 64'(out_valid), 64'd0);

    idx = 0; acc_prev = 1'b0; hold_prev = 1'b0; h_res = '0; h_bits = '0;
    cur = vecs[0];
    while (idx < vecs.size() || in_valid || q.size() != 0) begin
      if (acc_prev)
        chk(out_valid == 1'b1, "R10", "out_valid after accept", 64'(out_valid), 64'd1);
      if (hold_prev)
        chk(out_valid && out_res == h_res &&
            {out_so, out_ov, out_ov32, out_ca, out_ca32, out_cr0, out_cr0_valid} == h_bits,
            "R11", "held output", out_res, h_res);
      hold_prev = out_valid && !out_ready;
      h_res  = out_res;
      h_bits = {out_so, out_ov, out_ov32, out_ca, out_ca32, out_cr0, out_cr0_valid};
      chk(in_ready == (!out_valid || out_ready), "R10", "in_ready",
          64'(in_ready), 64'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10", "unexpected output", 64'd1, 64'd0);
        end else begin
          e = q.pop_front();
          chk(out_res == e.res, res_tag(e.op), "result", out_res, e.res);
          chk({out_ca, out_ca32} == {e.ca, e.ca32},
              (e.op >= 4'd2 && e.op <= 4'd4) ? "R3" : "R4", "carry pair",
              64'({out_ca, out_ca32}), 64'({e.ca, e.ca32}));
          chk({out_so, out_ov, out_ov32} == {e.so, e.ov, e.ov32},
              e.arith_oe ? "R7" : "R8", "so/ov/ov32",
              64'({out_so, out_ov, out_ov32}), 64'({e.so, e.ov, e.ov32}));
          chk({out_cr0, out_cr0_valid} == {e.cr, e.crv}, "R9", "cr0/valid",
              64'({out_cr0, out_cr0_valid}), 64'({e.cr, e.crv}));
        end
      end
      acc = in_valid && in_ready;
      if (acc) q.push_back(model(cur));
      acc_prev = acc;

      @(posedge clk);
      #1;
      if (!in_valid || acc) begin
        if (idx < vecs.size() && ($urandom % 5) != 0) begin
          cur = vecs[idx];
          idx++;
          in_valid = 1'b1;
          in_op = cur.op; in_a = cur.a; in_b = cur.b; in_imm = cur.imm;
          in_src_zero = cur.sz; in_rec = cur.rec; in_oe = cur.oe;
          in_so = cur.so; in_ov = cur.ov; in_ov32 = cur.ov32;
          in_ca = cur.ca; in_ca32 = cur.ca32;
        end else begin
          in_valid = 1'b0;
        end
      end
      out_ready = ($urandom % 10) < 7;
      @(negedge clk);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule